// File: doc/BRIEF.md
# Command-Queued SPI Master

This block is an SPI master fed by a queue of self-describing transmit entries. Every entry is a single 28-bit word that carries one data frame and also the settings for that frame. The settings are a choice of one of four attribute presets, a chip-select pattern, a flag that keeps chip select held into the next frame, and a flag that marks the entry as last in its group. The engine therefore switches frame length, clock mode, bit rate and target device between consecutive frames, and no control-path intervention is needed between them.

Entries go into a four-deep transmit FIFO through a push port. Each received word lands in a separate four-deep receive FIFO and is read through a pop port. Two request outputs are meant for a DMA engine: one says the transmit FIFO can take an entry, the other says the receive FIFO holds a word. The four presets are static configuration inputs, and each preset gives a frame length, a clock polarity, a clock phase and a half-period divider. When strobe mode is selected, the top chip-select line stops following the pattern. It then acts as a qualifying strobe that is active only while the other lines are stable, so the other lines can be decoded externally without glitches.

The control is a four-state machine:
- IDLE: chip select released, clock at its idle level.
- SETUP: chip select driven, first data bit presented, one half period.
- SHIFT: 2N clock edges for an N-bit frame.
- HOLD: chip select still driven, one half period.

The transitions are:
- IDLE→SETUP (start): an entry is queued and the receive FIFO has room.
- SETUP→SHIFT: the setup half period has elapsed.
- SHIFT→HOLD (finish): one half period after the last edge, the received word is written.
- HOLD→SETUP (chain): the finished entry asked for continuous select, the next queued entry has the same pattern, and the receive FIFO has room.
- HOLD→IDLE (release): any other case.

Top module: `spiq_master`

## Requirements
- R1: A transmit entry is laid out as bit 27 last-flag, bit 26 continuous-select flag, bits 25:24 preset select, bits 23:16 chip-select pattern, bits 15:0 data. The frame uses the preset chosen by bits 25:24 only.
- R2: Each preset is 10 bits wide inside `preset_i`, with preset k at bits 10k+9:10k. Its fields are bits 3:0 length code, bit 4 CPOL, bit 5 CPHA and bits 9:6 divider. The frame has N = code+1 bits, and codes below 3 give N = 4. A frame produces exactly 2N SCK transitions.
- R3: The transmit FIFO holds four entries. `tx_req_o` is high exactly when it is not full, and a push while it is full is discarded.
- R4: The receive FIFO holds four words in arrival order. `rx_req_o` is high exactly when it is not empty, and a pop while it is empty has no effect. Data is shifted MSB first, both out and in. The received word is right-justified to N bits with zeros above.
- R5: SCK rests at the CPOL of the current frame outside SHIFT. With CPHA=0, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA=1, MOSI changes on leading edges after the first one and MISO is sampled on trailing edges. With MOSI looped to MISO, every mode returns the transmitted bits.
- R6: With divider d, every SCK half period lasts d+1 clock cycles. This includes the time from chip-select activation to the first SCK edge.
- R7: Chip-select outputs are active low. During a frame, `cs_n_o[i]` is low exactly where pattern bit i is 1, and all lines are high in IDLE.
- R8: When a finished entry has the continuous flag set and the next queued entry carries the same pattern, chip select stays low between the two frames. When either condition fails, chip select is released between them.
- R9: When `strobe_mode_i` is high, `cs_n_o[7]` ignores pattern bit 7. It is low only during SHIFT, so it never changes in the same cycle as `cs_n_o[6:0]`.
- R10: `eot_o` pulses for one cycle when a frame whose entry has the last-flag set completes, and only then.
- R11: No frame starts while the receive FIFO is full, and SCK stays still during that time. The queue resumes after a pop, and no data is lost or reordered.
- R12: In and after reset, all chip selects are high, SCK is low, `tx_req_o` is high and `rx_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push_i | input | 1 | Push a transmit entry |
| tx_entry_i | input | 28 | Transmit entry (command and data) |
| tx_req_o | output | 1 | Transmit FIFO can accept an entry |
| rx_pop_i | input | 1 | Pop the head received word |
| rx_data_o | output | 16 | Head of the receive FIFO |
| rx_req_o | output | 1 | Receive FIFO holds a word |
| preset_i | input | 40 | Four attribute presets |
| strobe_mode_i | input | 1 | Use chip-select line 7 as a strobe |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 8 | Active-low chip selects |
| eot_o | output | 1 | End-of-group pulse |

## Verification
A wrong bit or edge counter shows within the same frame. The SCK transition count differs from 2N, or the looped-back word comes back shifted or truncated, and both are visible when chip select releases. A wrong half-period counter shows as an uneven spacing between SCK edges from the first edge onward. A corrupted FIFO pointer or count shows up as a reordered, lost or duplicated word, or as a request line that disagrees with the occupancy, no later than the pops that drain the queue. Errors in the chain or strobe decision show as an extra or missing chip-select activation, or as strobe-low cycles where the other lines move.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
    localparam int DATA_W   = 16;
    localparam int CS_W     = 8;
    localparam int SEL_W    = 2;
    localparam int N_PRESET = 4;
    localparam int FS_W     = 4;
    localparam int DIV_W    = 4;
    localparam int ATTR_W   = FS_W + 2 + DIV_W;
    localparam int ENTRY_W  = 2 + SEL_W + CS_W + DATA_W;

    typedef struct packed {
        logic              last;
        logic              cont;
        logic [SEL_W-1:0]  sel;
        logic [CS_W-1:0]   cs;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpha;
        logic             cpol;
        logic [FS_W-1:0]  fsz;
    } attr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } state_t;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full_o  = (cnt == CW'(DEPTH));
    assign empty_o = (cnt == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rdata_o = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R3: a push into a full FIFO leaves the occupancy unchanged
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (cnt == $past(cnt)));

    // R4: a pop from an empty FIFO leaves the occupancy unchanged
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/spiq_engine.sv
module spiq_engine
    import spiq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CS_W,
    parameter int NP = N_PRESET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  entry_t             head_i,
    input  logic               tx_empty_i,
    output logic               tx_pop_o,
    input  logic               rx_full_i,
    output logic               rx_wr_o,
    output logic [DW-1:0]      rx_wdata_o,
    input  logic [NP*ATTR_W-1:0] preset_i,
    input  logic               strobe_mode_i,
    input  logic               miso_i,
    output logic               sck_o,
    output logic               mosi_o,
    output logic [CW-1:0]      cs_n_o,
    output logic               eot_o
);
    localparam int NW = $clog2(DW) + 1;
    localparam int EW = NW + 1;

    state_t            st, nxt;
    attr_t             presets [NP];
    attr_t             pa;
    logic [DIV_W-1:0]  cnt, div_q;
    logic [EW-1:0]     edge_q;
    logic [NW-1:0]     n_q, n_new;
    logic [DW-1:0]     txsr, rxsr;
    logic [CW-1:0]     cs_q;
    logic              cont_q, last_q, cpol_q, cpha_q, tog;
    logic              half_done, fin_edges, start_go, chain_go, load, finish;
    logic              do_edge, lead, sample, shift, active;

    always_comb begin
        for (int k = 0; k < NP; k++) presets[k] = attr_t'(preset_i[k*ATTR_W +: ATTR_W]);
    end

    assign pa        = presets[head_i.sel];
    assign n_new     = (pa.fsz < FS_W'(3)) ? NW'(4) : NW'(pa.fsz) + NW'(1);
    assign half_done = (cnt == div_q);
    assign fin_edges = (edge_q == {n_q, 1'b0});
    assign start_go  = (st == ST_IDLE) && !tx_empty_i && !rx_full_i;
    assign chain_go  = (st == ST_HOLD) && half_done && cont_q && !tx_empty_i
                       && !rx_full_i && (head_i.cs == cs_q);
    assign load      = start_go || chain_go;
    assign finish    = (st == ST_SHIFT) && half_done && fin_edges;
    assign do_edge   = half_done && ((st == ST_SETUP) || ((st == ST_SHIFT) && !fin_edges));
    assign lead      = !edge_q[0];
    assign sample    = do_edge && (lead ^ cpha_q);
    assign shift     = do_edge && (cpha_q ? (lead && (edge_q != '0)) : !lead);

    // state transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (start_go)  nxt = ST_SETUP;
            ST_SETUP: if (half_done) nxt = ST_SHIFT;
            ST_SHIFT: if (finish)    nxt = ST_HOLD;
            ST_HOLD:  if (half_done) nxt = chain_go ? ST_SETUP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; div_q <= '0; edge_q <= '0; n_q <= NW'(4);
            txsr <= '0; rxsr <= '0; cs_q <= '0;
            cont_q <= 1'b0; last_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; tog <= 1'b0;
        end else if (load) begin
            cnt    <= '0;
            div_q  <= pa.div;
            edge_q <= '0;
            n_q    <= n_new;
            txsr   <= head_i.data << (NW'(DW) - n_new);
            rxsr   <= '0;
            cs_q   <= head_i.cs;
            cont_q <= head_i.cont;
            last_q <= head_i.last;
            cpol_q <= pa.cpol;
            cpha_q <= pa.cpha;
            tog    <= 1'b0;
        end else if (st != ST_IDLE) begin
            cnt <= half_done ? '0 : cnt + DIV_W'(1);
            if (do_edge) begin
                tog    <= ~tog;
                edge_q <= edge_q + EW'(1);
            end
            if (sample) rxsr <= {rxsr[DW-2:0], miso_i};
            if (shift)  txsr <= {txsr[DW-2:0], 1'b0};
        end
    end

    // outputs
    always_comb begin
        active     = (st != ST_IDLE);
        sck_o      = cpol_q ^ tog;
        mosi_o     = txsr[DW-1];
        cs_n_o     = ~(cs_q & {CW{active}});
        if (strobe_mode_i) cs_n_o[CW-1] = (st != ST_SHIFT);
        tx_pop_o   = load;
        rx_wr_o    = finish;
        rx_wdata_o = rxsr;
        eot_o      = finish && last_q;
    end

    // R9: the strobe line is active only while the other lines are stable
    p_strobe_settled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_mode_i && !cs_n_o[CW-1]) |-> $stable(cs_n_o[CW-2:0]));

    // R11: no frame begins while the receive FIFO is full
    p_no_start_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && rx_full_i) |=> (st == ST_IDLE));

    // R5: clock rests at the frame polarity when idle
    p_sck_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (sck_o == cpol_q));

    // R4: one receive write per frame
    p_one_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr_o |=> !rx_wr_o);

    // R8: chaining keeps chip select unchanged
    p_cs_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_mode_i && chain_go) |=> (cs_n_o == $past(cs_n_o)));
endmodule

// File: rtl/spiq_master.sv
module spiq_master
    import spiq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_push_i,
    input  logic [ENTRY_W-1:0]         tx_entry_i,
    output logic                       tx_req_o,
    input  logic                       rx_pop_i,
    output logic [DATA_W-1:0]          rx_data_o,
    output logic                       rx_req_o,
    input  logic [N_PRESET*ATTR_W-1:0] preset_i,
    input  logic                       strobe_mode_i,
    output logic                       sck_o,
    output logic                       mosi_o,
    input  logic                       miso_i,
    output logic [CS_W-1:0]            cs_n_o,
    output logic                       eot_o
);
    logic [ENTRY_W-1:0] head_raw;
    logic               tx_full, tx_empty, tx_pop;
    logic               rx_full, rx_empty, rx_wr;
    logic [DATA_W-1:0]  rx_wdata;

    spiq_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push_i(tx_push_i), .wdata_i(tx_entry_i),
        .pop_i(tx_pop), .rdata_o(head_raw), .full_o(tx_full), .empty_o(tx_empty));

    spiq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push_i(rx_wr), .wdata_i(rx_wdata),
        .pop_i(rx_pop_i), .rdata_o(rx_data_o), .full_o(rx_full), .empty_o(rx_empty));

    spiq_engine u_eng (
        .clk(clk), .rst_n(rst_n), .head_i(entry_t'(head_raw)), .tx_empty_i(tx_empty),
        .tx_pop_o(tx_pop), .rx_full_i(rx_full), .rx_wr_o(rx_wr), .rx_wdata_o(rx_wdata),
        .preset_i(preset_i), .strobe_mode_i(strobe_mode_i), .miso_i(miso_i),
        .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .eot_o(eot_o));

    assign tx_req_o = !tx_full;
    assign rx_req_o = !rx_empty;
endmodule

// File: tb/sim_spiq_master.sv
module sim_spiq_master;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_push = 1'b0;
    logic [27:0] tx_entry = '0;
    logic        rx_pop = 1'b0;
    logic [39:0] preset = '0;
    logic        strobe_mode = 1'b0;
    logic        tx_req, rx_req, sck, mosi, eot;
    logic [15:0] rx_data;
    logic [7:0]  cs_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    spiq_master u0 (
        .clk(clk), .rst_n(rst_n), .tx_push_i(tx_push), .tx_entry_i(tx_entry),
        .tx_req_o(tx_req), .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_req_o(rx_req),
        .preset_i(preset), .strobe_mode_i(strobe_mode), .sck_o(sck), .mosi_o(mosi),
        .miso_i(mosi), .cs_n_o(cs_n), .eot_o(eot));

    // port monitor, sampled on falling edges
    int   cyc = 0, activations = 0, edges = 0, tog_total = 0, eot_cnt = 0;
    int   act_cyc = 0, last_tog = 0, setup_gap = 0, gmin = 0, gmax = 0;
    int   strobe_lo = 0, strobe_bad = 0;
    bit   first_tog = 1'b0, prev_act = 1'b0, prev_sck = 1'b0;
    logic [7:0] prev_cs = 8'hFF, cs_seen = 8'hFF;

    always @(negedge clk) begin
        bit act;
        cyc++;
        act = (cs_n != 8'hFF);
        if (rst_n) begin
            if (act && !prev_act) begin
                activations++;
                edges = 0; first_tog = 1'b1; act_cyc = cyc;
                gmin = 999; gmax = 0; cs_seen = cs_n;
            end else if (act && prev_act && (sck != prev_sck)) begin
                edges++; tog_total++;
                if (first_tog) begin
                    setup_gap = cyc - act_cyc; first_tog = 1'b0;
                end else begin
                    if (cyc - last_tog < gmin) gmin = cyc - last_tog;
                    if (cyc - last_tog > gmax) gmax = cyc - last_tog;
                end
                last_tog = cyc;
            end
            if (strobe_mode && !cs_n[7]) begin
                strobe_lo++;
                if (cs_n[6:0] != prev_cs[6:0]) strobe_bad++;
            end
            if (eot) eot_cnt++;
        end
        prev_act = act; prev_sck = sck; prev_cs = cs_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic [9:0] mk(input int fsz, input int cpol, input int cpha, input int dv);
        return {4'(dv), 1'(cpha), 1'(cpol), 4'(fsz)};
    endfunction

    function automatic [27:0] ent(input int last, input int cont, input int sel,
                                  input int cs, input int data);
        return {1'(last), 1'(cont), 2'(sel), 8'(cs), 16'(data)};
    endfunction

    task automatic push(input logic [27:0] e);
        @(negedge clk); tx_push = 1'b1; tx_entry = e;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic wait_rx(input string req);
        int n = 0;
        while (!rx_req && n < 3000) begin @(negedge clk); n++; end
        chk(rx_req, req, 0, 1);
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (cs_n != 8'hFF && n < 3000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic pop_chk(input int exp, input string req);
        @(negedge clk);
        chk(rx_data == 16'(exp), req, int'(rx_data), exp);
        rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int a0, e0, t0, lo0, bad0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(cs_n == 8'hFF, "R12 cs in reset", int'(cs_n), 255);
        chk(sck == 1'b0, "R12 sck in reset", int'(sck), 0);
        chk(tx_req == 1'b1 && rx_req == 1'b0, "R12 requests in reset",
            int'({tx_req, rx_req}), 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 8'hFF && !rx_req, "R12 after reset", int'(cs_n), 255);

        // R1 R2 R5 R6 R7: sweep frame sizes, modes and presets
        e0 = eot_cnt;
        for (int sz = 4; sz <= 16; sz++) begin
            for (int md = 0; md < 4; md++) begin
                int dv, cpol, cpha, data, pat, expd;
                dv = (sz + md) % 4; cpol = md & 1; cpha = (md >> 1) & 1;
                for (int k = 0; k < 4; k++)
                    preset[k*10 +: 10] = mk(15 - k, 1 - cpol, 1 - cpha, 3);
                preset[md*10 +: 10] = mk(sz - 1, cpol, cpha, dv);
                data = (16'hB4D2 ^ 16'(sz * 97 + md * 13));
                pat  = (1 << (sz % 7)) | 1;
                expd = data & ((1 << sz) - 1);
                push(ent(1, 0, md, pat, data));
                wait_rx("R4 frame done");
                wait_idle();
                chk(edges == 2 * sz, "R2 sck transitions", edges, 2 * sz);
                chk(gmin == dv + 1 && gmax == dv + 1, "R6 half period", gmax, dv + 1);
                chk(setup_gap == dv + 1, "R6 setup half period", setup_gap, dv + 1);
                chk(sck == 1'(cpol), "R5 idle level", int'(sck), cpol);
                chk(cs_seen == ~8'(pat), "R7 cs pattern", int'(cs_seen), int'(~8'(pat)));
                pop_chk(expd, "R1 R5 loopback data");
            end
        end
        chk(eot_cnt - e0 == 52, "R10 eot per last entry", eot_cnt - e0, 52);

        // R2 length clamp: code 1 gives 4 bits
        preset[9:0] = mk(1, 0, 0, 0);
        push(ent(0, 0, 0, 1, 16'hFFFF));
        wait_rx("R2 clamp frame");
        wait_idle();
        chk(edges == 8, "R2 clamp transitions", edges, 8);
        pop_chk(16'h000F, "R2 clamp data");

        // R3 R11 FIFO full and receive stall
        preset[9:0] = mk(3, 0, 0, 0);
        for (int i = 0; i < 4; i++) push(ent(0, 0, 0, 2, i + 1));
        repeat (300) @(negedge clk);
        chk(rx_req, "R4 words waiting", int'(rx_req), 1);
        for (int i = 4; i < 8; i++) push(ent(0, 0, 0, 2, i + 1));
        repeat (5) @(negedge clk);
        chk(!tx_req, "R3 tx full request low", int'(tx_req), 0);
        push(ent(0, 0, 0, 2, 14));
        t0 = tog_total;
        repeat (100) @(negedge clk);
        chk(tog_total == t0, "R11 sck still while rx full", tog_total - t0, 0);
        for (int i = 0; i < 8; i++) begin
            wait_rx("R11 resume");
            pop_chk(i + 1, "R11 order kept");
        end
        repeat (300) @(negedge clk);
        chk(!rx_req, "R3 push when full discarded", int'(rx_req), 0);
        chk(tx_req, "R3 tx request back", int'(tx_req), 1);
        @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        push(ent(0, 0, 0, 2, 9));
        wait_rx("R4 after empty pop");
        pop_chk(9, "R4 empty pop ignored");

        // R8 R10 continuous chip select
        preset[9:0] = mk(7, 0, 1, 1);
        a0 = activations; e0 = eot_cnt;
        push(ent(0, 1, 0, 5, 8'h11));
        push(ent(0, 1, 0, 5, 8'h22));
        push(ent(1, 0, 0, 5, 8'h33));
        wait_rx("R8 chain"); pop_chk(8'h11, "R8 chain data 1");
        wait_rx("R8 chain"); pop_chk(8'h22, "R8 chain data 2");
        wait_rx("R8 chain"); pop_chk(8'h33, "R8 chain data 3");
        wait_idle();
        chk(activations - a0 == 1, "R8 held select", activations - a0, 1);
        chk(eot_cnt - e0 == 1, "R10 only last flagged", eot_cnt - e0, 1);
        a0 = activations; e0 = eot_cnt;
        push(ent(1, 1, 0, 5, 8'h44));
        push(ent(1, 0, 0, 10, 8'h55));
        wait_rx("R8 break"); pop_chk(8'h44, "R8 break data 1");
        wait_rx("R8 break"); pop_chk(8'h55, "R8 break data 2");
        wait_idle();
        chk(activations - a0 == 2, "R8 pattern change releases", activations - a0, 2);
        chk(eot_cnt - e0 == 2, "R10 two flagged", eot_cnt - e0, 2);

        // R9 strobe mode
        strobe_mode = 1'b1;
        lo0 = strobe_lo; bad0 = strobe_bad;
        push(ent(0, 0, 0, 3, 8'h5A));
        wait_rx("R9 strobe frame"); wait_idle();
        chk(strobe_lo > lo0, "R9 strobe active", strobe_lo - lo0, 1);
        chk(strobe_bad == bad0, "R9 strobe glitch-free", strobe_bad - bad0, 0);
        chk(cs_seen[6:0] == 7'h7C, "R9 other lines", int'(cs_seen[6:0]), 124);
        pop_chk(8'h5A, "R9 strobe data");
        strobe_mode = 1'b0;
        push(ent(0, 0, 0, 8'h81, 8'hC3));
        wait_rx("R7 line 7 frame"); wait_idle();
        chk(cs_seen == 8'h7E, "R7 line 7 follows pattern", int'(cs_seen), 126);
        pop_chk(8'hC3, "R7 line 7 data");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule